// File: doc/BRIEF.md
# Program Memory Verify Readout Port

This block gives an external programming fixture a way to read the on-chip program ROM back over the shared 8-bit bus. It only responds while a mode input is asserted. In this design that input stands in for the high-voltage sense on the external-access pin.

The chip reset pin has three jobs here. While it is low, the fixture presents a 10-bit ROM address: the low byte on the bus inputs and the top two bits on two port lines. When the pin rises, the block latches that address. While the pin stays high, the block drives the addressed ROM byte onto the bus. When the pin goes low again the bus returns to being an input, ready for the next address.

The reset pin and the mode input arrive asynchronously. Each passes through a two-flop synchroniser before any edge detection.

Top module: `pmem_verify_port`

## Requirements
- R1: While `rst_n` is low, `bus_oe_o` is 0 and `bus_o` is 0.
- R2: Read mode requires both `xa_hv_i` high and `pin_rst_i` low. The bus is never driven while `xa_hv_i` is low.
- R3: The address is formed from `bus_i` as bits 7:0 and `port_lo_i[1:0]` as bits 9:8, both sampled while in read mode.
- R4: A 0-to-1 transition of `pin_rst_i` in read mode latches the address. Three clock edges after the pin rises, `bus_oe_o` is 1 and `bus_o` holds the ROM byte at that address.
- R5: While `pin_rst_i` stays high, changes on `bus_i` and `port_lo_i` have no effect: `bus_o` holds its value.
- R6: After `pin_rst_i` falls, `bus_oe_o` is 0 no later than the second clock edge.
- R7: After `xa_hv_i` falls, `bus_oe_o` is 0 no later than the second clock edge.
- R8: The block does not drive the bus in two cases: a rise of `pin_rst_i` while `xa_hv_i` is low, and `xa_hv_i` rising while `pin_rst_i` is already high.
- R9: The ROM holds 1024 bytes. The byte at address A is A[7:0] XOR {A[9:8],A[9:8],A[9:8],A[9:8]} XOR `SEED`.
- R10: A new address takes effect only at the next rising edge of `pin_rst_i`, after the pin has returned low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| xa_hv_i | input | 1 | Mode sense, high selects verify readout |
| pin_rst_i | input | 1 | Reset pin: address strobe and output enable |
| bus_i | input | 8 | Bus input, low address byte |
| port_lo_i | input | 2 | Two low port lines, address bits 9:8 |
| bus_o | output | 8 | ROM byte driven onto the bus |
| bus_oe_o | output | 1 | Bus output enable, 0 means high impedance |

## Verification
The bench builds the block with `SEED` set to 8'h3C instead of the default. This means the expected bytes cannot line up by chance with plain address bits. The address set covers 0, 1023 and mixed upper-bit patterns, so an error in how the two port lines fold into the address shows up in the data. Sequences that reorder the mode and reset-pin edges exercise the cases where the block must stay silent.

// File: rtl/pvr_pkg.sv
`timescale 1ns/1ps
package pvr_pkg;
  localparam int DATA_W = 8;
  localparam int HI_W   = 2;
  localparam int ADDR_W = DATA_W + HI_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  // Contents of one ROM location, evaluated at elaboration.
  function automatic byte_t rom_byte(input addr_t a, input byte_t seed);
    byte_t hi_rep;
    for (int i = 0; i < DATA_W / HI_W; i++) hi_rep[i*HI_W +: HI_W] = a[ADDR_W-1 -: HI_W];
    return a[DATA_W-1:0] ^ hi_rep ^ seed;
  endfunction
endpackage

// File: rtl/pvr_sync.sv
`timescale 1ns/1ps
module pvr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] chain_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign chain_d[s] = d_i;
    end else begin : g_rest
      assign chain_d[s] = chain_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_d[s];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pvr_ctrl.sv
`timescale 1ns/1ps
module pvr_ctrl
  import pvr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_s,
  input  logic            strb_s,
  input  logic [DATA_W-1:0] bus_i,
  input  logic [HI_W-1:0] port_lo_i,
  output logic            rd_en_o,
  output addr_t           rd_addr_o,
  output logic            oe_o
);
  logic  strb_d_q, strb_d_d;
  addr_t addr_q, addr_d;
  logic  drive_q, drive_d;
  logic  sample_en, rise, latch;

  always_comb begin
    sample_en = mode_s & ~strb_s;
    rise      = strb_s & ~strb_d_q;
    latch     = rise & mode_s;
    strb_d_d  = strb_s;
    addr_d    = sample_en ? {port_lo_i, bus_i} : addr_q;
    if (latch)                 drive_d = 1'b1;
    else if (mode_s && strb_s) drive_d = drive_q;
    else                       drive_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_d_q <= 1'b0;
      addr_q   <= '0;
      drive_q  <= 1'b0;
    end else begin
      strb_d_q <= strb_d_d;
      addr_q   <= addr_d;
      drive_q  <= drive_d;
    end
  end

  assign rd_en_o   = latch;
  assign rd_addr_o = addr_q;
  assign oe_o      = drive_q & mode_s & strb_s;

  // R6
  strobe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_s |=> !drive_q);
  // R7
  mode_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_s |=> !drive_q);
  // R4
  drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_q) |-> $past(mode_s && strb_s && !strb_d_q));
endmodule

// File: rtl/pvr_rom.sv
`timescale 1ns/1ps
module pvr_rom
  import pvr_pkg::*;
#(
  parameter byte_t SEED = 8'hA5
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_en_i,
  input  addr_t rd_addr_i,
  output byte_t rd_data_o
);
  byte_t mem [DEPTH];
  byte_t data_q, data_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_fill
    assign mem[g] = rom_byte(addr_t'(g), SEED);
  end

  always_comb data_d = rd_en_i ? mem[rd_addr_i] : data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign rd_data_o = data_q;
endmodule

// File: rtl/pmem_verify_port.sv
`timescale 1ns/1ps
module pmem_verify_port #(
  parameter logic [7:0] SEED        = 8'hA5,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xa_hv_i,
  input  logic       pin_rst_i,
  input  logic [7:0] bus_i,
  input  logic [1:0] port_lo_i,
  output logic [7:0] bus_o,
  output logic       bus_oe_o
);
  import pvr_pkg::*;

  logic [1:0] pins_s;
  logic       mode_s, strb_s, rd_en, oe;
  addr_t      rd_addr;
  byte_t      rd_data;

  pvr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({xa_hv_i, pin_rst_i}), .q_o(pins_s)
  );
  assign mode_s = pins_s[1];
  assign strb_s = pins_s[0];

  pvr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_s(mode_s), .strb_s(strb_s),
    .bus_i(bus_i), .port_lo_i(port_lo_i),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .oe_o(oe)
  );

  pvr_rom #(.SEED(SEED)) u_rom (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  assign bus_oe_o = oe;
  assign bus_o    = oe ? rd_data : '0;

  // R5
  held_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe_o && $past(bus_oe_o)) |-> $stable(bus_o));
endmodule

// File: tb/sim_pmem_verify_port.sv
`timescale 1ns/1ps
module sim_pmem_verify_port;
  localparam logic [7:0] SEED = 8'h3C;

  logic clk = 1'b0;
  logic rst_n, xa_hv, pin_rst;
  logic [7:0] bus_in, bus_out;
  logic [1:0] port_lo;
  logic oe;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  logic [9:0] adr_q[$];

  always #10 clk = ~clk;

  pmem_verify_port #(.SEED(SEED)) u0 (
    .clk(clk), .rst_n(rst_n), .xa_hv_i(xa_hv), .pin_rst_i(pin_rst),
    .bus_i(bus_in), .port_lo_i(port_lo), .bus_o(bus_out), .bus_oe_o(oe)
  );

  function automatic logic [7:0] model(input logic [9:0] a);
    return a[7:0] ^ {4{a[9:8]}} ^ SEED;
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: each new drive of the bus is compared with the next scoreboard item.
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && oe && !prev_oe) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected drive", {1'b1, bus_out}, 9'h000);
      end else begin
        logic [7:0] e;
        logic [9:0] a;
        e = exp_q.pop_front();
        a = adr_q.pop_front();
        check($sformatf("R4/R9/R3 addr %0d", a), {1'b1, bus_out}, {1'b1, e});
      end
    end
    prev_oe = oe;
  end

  task automatic present(input logic [9:0] a);
    @(negedge clk);
    xa_hv = 1'b1; pin_rst = 1'b0; bus_in = a[7:0]; port_lo = a[9:8];
    repeat (4) @(negedge clk);
  endtask

  // Full read cycle; leaves the pin high and the bus driven.
  task automatic read_hold(input logic [9:0] a);
    present(a);
    exp_q.push_back(model(a)); adr_q.push_back(a);
    pin_rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 oe three edges after rise", {1'b0, oe}, 9'h001);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read(input logic [9:0] a);
    read_hold(a);
    bus_in = ~a[7:0]; port_lo = ~a[9:8];
    repeat (3) @(negedge clk);
    check("R5 inputs ignored while high", {oe, bus_out}, {1'b1, model(a)});
    pin_rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 oe off after pin falls", {1'b0, oe}, 9'h000);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; xa_hv = 1'b0; pin_rst = 1'b0; bus_in = '0; port_lo = '0;
    repeat (3) @(negedge clk);
    check("R1 reset oe", {1'b0, oe}, 9'h000);
    check("R1 reset bus", {1'b0, bus_out}, 9'h000);
    rst_n = 1'b1;

    do_read(10'd0);
    do_read(10'd1023);
    do_read(10'h155);
    do_read(10'h2AA);
    do_read(10'h0FF);
    do_read(10'h100);   // R3 upper bits from the port lines
    do_read(10'h300);   // R10 new address after return low

    // R7: mode drop stops the drive
    read_hold(10'h07E);
    xa_hv = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 oe off after mode falls", {1'b0, oe}, 9'h000);
    pin_rst = 1'b0;
    repeat (3) @(negedge clk);

    // R8: rise with mode low, then mode rising with pin high
    xa_hv = 1'b0; bus_in = 8'h12; port_lo = 2'b01;
    repeat (3) @(negedge clk);
    pin_rst = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 no drive, mode low at rise", {1'b0, oe}, 9'h000);
    xa_hv = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 no drive, mode after rise", {1'b0, oe}, 9'h000);
    pin_rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 no drive in sample phase", {1'b0, oe}, 9'h000);

    do_read(10'h212);
    repeat (3) @(negedge clk);
    check("R4 scoreboard drained", 9'(exp_q.size()), 9'h000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule